// File: doc/BRIEF.md
# Parallel NOR Flash Command Engine

This block models the command side of a parallel NOR flash part on a synchronous clock. Chip select, write strobe, output strobe, a byte-width select and an active-low hardware reset are sampled on the clock. A write cycle is taken when the write strobe is seen falling while the chip is selected and the output strobe is high. A read cycle starts when the output strobe is seen falling while the chip is selected and the write strobe is high. Multi-write unlock sequences are decoded into program, sector erase, chip erase, a bypass mode for short programming, erase suspend and erase resume.

The storage is a small word array with a uniform sector map (`DEPTH` words in sectors of `SEC_WORDS`). The program and erase operations take a fixed number of clock cycles, set by parameters. While an operation runs, the block holds its ready output low and reads return status bits instead of array data. The array is not cleared by reset, so it keeps its contents across a hardware reset, as a real part does.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the block reads the array: `rdy` is 1, and `dq_oe` is nonzero only while `ce_n`=0, `oe_n`=0 and `we_n`=1. A read of a word then returns the stored word.
- R2: Driving `rst_n` low during a program abandons it. After release `rdy` is 1 and the target word keeps its old value.
- R3: Program takes four writes: 0xAA at 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then the data at the target. Bits can only be cleared, so the new word is the old word AND the data.
- R4: The write sequence 0xAA at 0x555, 0x55 at 0x2AA, 0x20 at 0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by the data programs a word. The writes 0x90 then 0x00 leave bypass mode, and after that a two-write program has no effect.
- R5: A write that breaks an unlock sequence (wrong address or data) returns the block to array read. The writes that follow do not start an operation.
- R6: `rdy` falls only at the clock edge after a write cycle. It stays 0 for the whole program or erase and returns to 1 when the operation ends.
- R7: A read during a program returns bit 7 as the complement of bit 7 of the programmed data. A read during an erase returns bit 7 as 0. Once the operation is done, the read returns the true data.
- R8: Bit 6 of the read data changes between two successive reads while an operation is busy.
- R9: Sector erase is the writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 0x30 at any address inside the sector. It sets every word of that sector to 0xFFFF and leaves the other sectors unchanged.
- R10: Chip erase is the same sequence ending with 0x10 at 0x555. It sets every word to 0xFFFF.
- R11: Writing 0xB0 during an erase suspends it. While suspended, `rdy` is 1 and words outside the erased sector read normally. Reads inside the erased sector return status with bit 7 = 1. A program to another sector is accepted, and a program into the erased sector is ignored (`rdy` stays 1).
- R12: Writing 0x30 while an erase is suspended resumes it (`rdy` goes to 0), and the erase then completes.
- R13: With `byte_n`=0, `dq_in[15]` is the byte address LSB (0 selects the low byte). Reads drive only bits 7:0 (`dq_oe`=0x00FF). Unlock addresses are byte addresses 0xAAA and 0x555, and a program clears bits only in the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Hardware reset, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| byte_n | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data in; bit 15 is the byte LSB in 8-bit mode |
| dq_out | output | 16 | Read data or status |
| dq_oe | output | 16 | Per-bit output drive enable |
| rdy | output | 1 | 1 = ready, 0 = busy |

## Verification
A full-array sweep first chip-erases the array, then programs every word with a pattern computed from its index. Overlapping second patterns follow, so the bench can tell a true AND from a plain overwrite or a wrong address decode. Status reads during program and during erase separate the three reporting paths. The bench then breaks unlock sequences, resets in the middle of a program, and uses bypass entry and exit, which shows that stray writes cannot start an operation. Sector erase, suspend with programs inside and outside the erased sector, resume, and byte-lane reads and programs check that the sector and byte decodes hit only the intended cells.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_ERS0, SQ_ERS1, SQ_ERS2, SQ_PGM, SQ_BYX
    } seq_e;

    typedef enum logic [1:0] {
        OP_NONE, OP_PGM, OP_PRE, OP_ERS
    } op_e;

    localparam logic [7:0] C_KEY1   = 8'hAA;
    localparam logic [7:0] C_KEY2   = 8'h55;
    localparam logic [7:0] C_PROG   = 8'hA0;
    localparam logic [7:0] C_ESETUP = 8'h80;
    localparam logic [7:0] C_CHIP   = 8'h10;
    localparam logic [7:0] C_SECT   = 8'h30;
    localparam logic [7:0] C_BYPASS = 8'h20;
    localparam logic [7:0] C_SUSP   = 8'hB0;
    localparam logic [7:0] C_RESUME = 8'h30;
    localparam logic [7:0] C_BYX1   = 8'h90;
    localparam logic [7:0] C_BYX2   = 8'h00;

    localparam logic [10:0] ADR_KEY1 = 11'h555;
    localparam logic [10:0] ADR_KEY2 = 11'h2AA;
endpackage

// File: rtl/nor_bus_if.sv
`timescale 1ns/1ps
module nor_bus_if #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              byte_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dq15,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              acc_en,
    output logic              byte_mode,
    output logic              lsb,
    output logic              key1,
    output logic              key2
);
    import nor_cmd_pkg::*;

    typedef struct packed {
        logic we;
        logic oe;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.we    = we_n;
        e_d.oe    = oe_n;
        byte_mode = ~byte_n;
        lsb       = byte_mode & dq15;
        wr_stb    = e_q.we & ~we_n & ~ce_n & oe_n;
        rd_stb    = e_q.oe & ~oe_n & ~ce_n & we_n;
        acc_en    = rst_n & ~ce_n & ~oe_n & we_n;
        key1      = (addr[10:0] == ADR_KEY1) && !(byte_mode && lsb);
        key2      = (addr[10:0] == ADR_KEY2) && (!byte_mode || lsb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '1;
        else        e_q <= e_d;
    end
endmodule

// File: rtl/nor_ctrl.sv
`timescale 1ns/1ps
module nor_ctrl #(
    parameter int DEPTH     = 32,
    parameter int SEC_WORDS = 8,
    parameter int PGM_CYC   = 16,
    parameter int PRE_CYC   = 8,
    parameter int ERS_CYC   = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic                          key1,
    input  logic                          key2,
    input  logic                          byte_mode,
    input  logic                          lsb,
    input  logic [15:0]                   wdata,
    input  logic [$clog2(DEPTH)-1:0]      wr_idx,
    output nor_cmd_pkg::op_e              op,
    output logic                          held,
    output logic                          ers_all,
    output logic [$clog2(DEPTH)-$clog2(SEC_WORDS)-1:0] ers_sec,
    output logic                          pgm_d7,
    output logic                          commit,
    output logic [$clog2(DEPTH)-1:0]      cm_idx,
    output logic [15:0]                   cm_mask,
    output logic                          fill_en,
    output logic                          fill_val
);
    import nor_cmd_pkg::*;

    localparam int ARR_AW  = $clog2(DEPTH);
    localparam int SEC_AW  = $clog2(SEC_WORDS);
    localparam int SEC_W   = ARR_AW - SEC_AW;
    localparam int MAX_AB  = (PGM_CYC > PRE_CYC) ? PGM_CYC : PRE_CYC;
    localparam int CNT_MAX = (MAX_AB > ERS_CYC) ? MAX_AB : ERS_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_e              seq;
        op_e               op;
        op_e               ers_ph;
        logic              held;
        logic              byp;
        logic              ers_all;
        logic [SEC_W-1:0]  ers_sec;
        logic [CNT_W-1:0]  ers_cnt;
        logic [CNT_W-1:0]  pgm_cnt;
        logic [ARR_AW-1:0] pgm_idx;
        logic [15:0]       pgm_mask;
        logic              pgm_d7;
    } st_t;

    st_t s_d, s_q;

    logic [7:0]       cmd;
    logic [SEC_W-1:0] wr_sec;
    logic [15:0]      mask;
    logic             locked;

    always_comb begin
        cmd    = wdata[7:0];
        wr_sec = wr_idx[ARR_AW-1 -: SEC_W];
        mask   = byte_mode ? (lsb ? {cmd, 8'hFF} : {8'hFF, cmd}) : wdata;
        locked = s_q.held && (s_q.ers_all || (wr_sec == s_q.ers_sec));

        s_d      = s_q;
        commit   = 1'b0;
        fill_en  = 1'b0;
        fill_val = 1'b0;

        if (s_q.op != OP_NONE) begin
            s_d.seq = SQ_IDLE;
            if (wr_stb && (cmd == C_SUSP) && (s_q.op != OP_PGM)) begin
                s_d.held   = 1'b1;
                s_d.ers_ph = s_q.op;
                s_d.op     = OP_NONE;
            end else begin
                case (s_q.op)
                    OP_PGM: begin
                        if (s_q.pgm_cnt == '0) begin
                            commit   = 1'b1;
                            s_d.op   = OP_NONE;
                        end else begin
                            s_d.pgm_cnt = s_q.pgm_cnt - 1'b1;
                        end
                    end
                    OP_PRE: begin
                        if (s_q.ers_cnt == '0) begin
                            fill_en     = 1'b1;
                            fill_val    = 1'b0;
                            s_d.op      = OP_ERS;
                            s_d.ers_cnt = CNT_W'(ERS_CYC - 1);
                        end else begin
                            s_d.ers_cnt = s_q.ers_cnt - 1'b1;
                        end
                    end
                    OP_ERS: begin
                        if (s_q.ers_cnt == '0) begin
                            fill_en  = 1'b1;
                            fill_val = 1'b1;
                            s_d.op   = OP_NONE;
                        end else begin
                            s_d.ers_cnt = s_q.ers_cnt - 1'b1;
                        end
                    end
                    default: s_d.op = OP_NONE;
                endcase
            end
        end else if (wr_stb) begin
            s_d.seq = SQ_IDLE;
            case (s_q.seq)
                SQ_IDLE: begin
                    if (s_q.byp) begin
                        if (cmd == C_PROG)      s_d.seq = SQ_PGM;
                        else if (cmd == C_BYX1) s_d.seq = SQ_BYX;
                    end else if (key1 && (cmd == C_KEY1)) begin
                        s_d.seq = SQ_UNL1;
                    end else if (s_q.held && (cmd == C_RESUME)) begin
                        s_d.op   = s_q.ers_ph;
                        s_d.held = 1'b0;
                    end
                end
                SQ_UNL1: if (key2 && (cmd == C_KEY2)) s_d.seq = SQ_UNL2;
                SQ_UNL2: begin
                    if (key1) begin
                        if (cmd == C_PROG)                     s_d.seq = SQ_PGM;
                        else if (cmd == C_ESETUP && !s_q.held) s_d.seq = SQ_ERS0;
                        else if (cmd == C_BYPASS)              s_d.byp = 1'b1;
                    end
                end
                SQ_ERS0: if (key1 && (cmd == C_KEY1)) s_d.seq = SQ_ERS1;
                SQ_ERS1: if (key2 && (cmd == C_KEY2)) s_d.seq = SQ_ERS2;
                SQ_ERS2: begin
                    if ((key1 && (cmd == C_CHIP)) || (cmd == C_SECT)) begin
                        s_d.op      = OP_PRE;
                        s_d.ers_cnt = CNT_W'(PRE_CYC - 1);
                        s_d.ers_all = (cmd == C_CHIP);
                        s_d.ers_sec = wr_sec;
                    end
                end
                SQ_PGM: begin
                    if (!locked) begin
                        s_d.op       = OP_PGM;
                        s_d.pgm_cnt  = CNT_W'(PGM_CYC - 1);
                        s_d.pgm_idx  = wr_idx;
                        s_d.pgm_mask = mask;
                        s_d.pgm_d7   = cmd[7];
                    end
                end
                SQ_BYX: if (cmd == C_BYX2) s_d.byp = 1'b0;
                default: s_d.seq = SQ_IDLE;
            endcase
        end

        op      = s_q.op;
        held    = s_q.held;
        ers_all = s_q.ers_all;
        ers_sec = s_q.ers_sec;
        pgm_d7  = s_q.pgm_d7;
        cm_idx  = s_q.pgm_idx;
        cm_mask = s_q.pgm_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/nor_array.sv
`timescale 1ns/1ps
module nor_array #(
    parameter int DEPTH     = 32,
    parameter int SEC_WORDS = 8
) (
    input  logic                      clk,
    input  logic                      commit,
    input  logic [$clog2(DEPTH)-1:0]  cm_idx,
    input  logic [15:0]               cm_mask,
    input  logic                      fill_en,
    input  logic                      fill_val,
    input  logic                      fill_all,
    input  logic [$clog2(DEPTH)-$clog2(SEC_WORDS)-1:0] fill_sec,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx,
    output logic [15:0]               rd_word
);
    localparam int ARR_AW = $clog2(DEPTH);
    localparam int SEC_AW = $clog2(SEC_WORDS);
    localparam int SEC_W  = ARR_AW - SEC_AW;

    logic [15:0] mem_d [DEPTH];
    logic [15:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (commit && (cm_idx == ARR_AW'(i)))
                mem_d[i] = mem_q[i] & cm_mask;
            if (fill_en && (fill_all || (SEC_W'(i >> SEC_AW) == fill_sec)))
                mem_d[i] = {16{fill_val}};
        end
        rd_word = mem_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end
endmodule

// File: rtl/nor_rdout.sv
`timescale 1ns/1ps
module nor_rdout #(
    parameter int SEC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              acc_en,
    input  logic              byte_mode,
    input  logic              lsb,
    input  logic [15:0]       rd_word,
    input  nor_cmd_pkg::op_e  op,
    input  logic              held,
    input  logic              ers_all,
    input  logic [SEC_W-1:0]  ers_sec,
    input  logic [SEC_W-1:0]  rd_sec,
    input  logic              pgm_d7,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe
);
    import nor_cmd_pkg::*;

    logic       tog_d, tog_q;
    logic       show_stat;
    logic [7:0] stat;
    logic [7:0] byte_val;

    always_comb begin
        tog_d = tog_q ^ (rd_stb && (op != OP_NONE));
        show_stat = (op != OP_NONE) || (held && (ers_all || (rd_sec == ers_sec)));
        case (op)
            OP_PGM:  stat = {~pgm_d7, tog_q, 6'b0};
            OP_NONE: stat = {1'b1, tog_q, 6'b0};
            default: stat = {1'b0, tog_q, 6'b0};
        endcase
        byte_val = show_stat ? stat : (lsb ? rd_word[15:8] : rd_word[7:0]);
        if (byte_mode)      dq_out = {8'h00, byte_val};
        else if (show_stat) dq_out = {8'h00, stat};
        else                dq_out = rd_word;
        dq_oe = acc_en ? (byte_mode ? 16'h00FF : 16'hFFFF) : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end
endmodule

// File: rtl/nor_cmd_engine.sv
`timescale 1ns/1ps
module nor_cmd_engine #(
    parameter int ADDR_W    = 11,
    parameter int DEPTH     = 32,
    parameter int SEC_WORDS = 8,
    parameter int PGM_CYC   = 16,
    parameter int PRE_CYC   = 8,
    parameter int ERS_CYC   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              byte_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              rdy
);
    import nor_cmd_pkg::*;

    localparam int ARR_AW = $clog2(DEPTH);
    localparam int SEC_AW = $clog2(SEC_WORDS);
    localparam int SEC_W  = ARR_AW - SEC_AW;

    logic              wr_stb, rd_stb, acc_en, byte_mode, lsb, key1, key2;
    op_e               op;
    logic              held, ers_all, pgm_d7, commit, fill_en, fill_val;
    logic [SEC_W-1:0]  ers_sec, rd_sec;
    logic [ARR_AW-1:0] idx, cm_idx;
    logic [15:0]       cm_mask, rd_word;

    assign idx    = addr[ARR_AW-1:0];
    assign rd_sec = idx[ARR_AW-1 -: SEC_W];
    assign rdy    = (op == OP_NONE);

    nor_bus_if #(.ADDR_W(ADDR_W)) bus_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_n(byte_n), .addr(addr), .dq15(dq_in[15]),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .acc_en(acc_en),
        .byte_mode(byte_mode), .lsb(lsb), .key1(key1), .key2(key2)
    );

    nor_ctrl #(
        .DEPTH(DEPTH), .SEC_WORDS(SEC_WORDS),
        .PGM_CYC(PGM_CYC), .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .key1(key1), .key2(key2),
        .byte_mode(byte_mode), .lsb(lsb), .wdata(dq_in), .wr_idx(idx),
        .op(op), .held(held), .ers_all(ers_all), .ers_sec(ers_sec),
        .pgm_d7(pgm_d7), .commit(commit), .cm_idx(cm_idx), .cm_mask(cm_mask),
        .fill_en(fill_en), .fill_val(fill_val)
    );

    nor_array #(.DEPTH(DEPTH), .SEC_WORDS(SEC_WORDS)) arr_i (
        .clk(clk), .commit(commit), .cm_idx(cm_idx), .cm_mask(cm_mask),
        .fill_en(fill_en), .fill_val(fill_val), .fill_all(ers_all),
        .fill_sec(ers_sec), .rd_idx(idx), .rd_word(rd_word)
    );

    nor_rdout #(.SEC_W(SEC_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .acc_en(acc_en),
        .byte_mode(byte_mode), .lsb(lsb), .rd_word(rd_word), .op(op),
        .held(held), .ers_all(ers_all), .ers_sec(ers_sec), .rd_sec(rd_sec),
        .pgm_d7(pgm_d7), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/nor_cmd_engine_chk.sv
`timescale 1ns/1ps
module nor_cmd_engine_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             byte_n,
    input logic [15:0]      dq_out,
    input logic [15:0]      dq_oe,
    input logic             rdy,
    input logic             wr_stb,
    input nor_cmd_pkg::op_e op,
    input logic             held,
    input logic             pgm_d7
);
    import nor_cmd_pkg::*;

    p_drive_only_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 16'h0000) |-> (!ce_n && !oe_n && we_n));

    p_ready_after_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rdy);

    p_busy_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(wr_stb));

    p_poll_bit7_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PGM && dq_oe[7]) |-> (dq_out[7] == !pgm_d7));

    p_suspend_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (held && op != OP_PGM) |-> rdy);

    p_byte_upper_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_n |-> (dq_oe[15:8] == 8'h00));
endmodule

bind nor_cmd_engine nor_cmd_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_n(byte_n), .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy),
    .wr_stb(wr_stb), .op(op), .held(held), .pgm_d7(pgm_d7)
);

// File: tb/nor_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_engine_tb_top;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, byte_n = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;
    logic        rdy;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] model [DEPTH];

    always #2 clk = ~clk;

    nor_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .byte_n(byte_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .rdy(rdy)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk); ce_n = 1'b0; addr = a; dq_in = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [10:0] a, input logic lsb, output logic [15:0] v, output logic [15:0] oe);
        @(negedge clk); ce_n = 1'b0; addr = a; dq_in = {lsb, 15'b0}; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk); v = dq_out; oe = dq_oe; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_rdy();
        for (int n = 0; n < 2000 && !rdy; n++) @(negedge clk);
    endtask

    task automatic prog4(input int i, input logic [15:0] d);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0);
        wr(11'(i), d);
    endtask

    task automatic erase_seq(input logic [10:0] a, input logic [7:0] c);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a, {8'h00, c});
    endtask

    task automatic sweep(input string tag);
        logic [15:0] v, oe;
        for (int i = 0; i < DEPTH; i++) begin
            rd(11'(i), 1'b0, v, oe);
            check(tag, v, model[i]);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input int k);
        return 16'(i * 4951 + k * 777) ^ 16'h3C5A;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2, oe;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {15'b0, rdy}, 16'h1);
        check("R1 no drive when idle", dq_oe, 16'h0000);

        // R10 chip erase with R6/R7/R8 status during erase
        erase_seq(11'h555, 8'h10);
        check("R6 busy during erase", {15'b0, rdy}, 16'h0);
        rd(11'h003, 1'b0, v, oe);
        rd(11'h003, 1'b0, v2, oe);
        check("R7 erase poll bit7", {15'b0, v[7]}, 16'h0);
        check("R8 toggle in erase", {15'b0, v[6] ^ v2[6]}, 16'h1);
        wait_rdy();
        check("R6 ready after erase", {15'b0, rdy}, 16'h1);
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        sweep("R10 chip erase");

        // R3 program every word, R7/R8 status on one of them
        for (int i = 0; i < DEPTH; i++) begin
            prog4(i, pat(i, 0));
            model[i] &= pat(i, 0);
            if (i == 5) begin
                check("R6 busy during program", {15'b0, rdy}, 16'h0);
                rd(11'(i), 1'b0, v, oe);
                rd(11'(i), 1'b0, v2, oe);
                check("R7 program poll bit7", {15'b0, v[7]}, {15'b0, ~pat(i, 0)} & 16'h0080 ? 16'h1 : 16'h0);
                check("R8 toggle in program", {15'b0, v[6] ^ v2[6]}, 16'h1);
                wait_rdy();
                rd(11'(i), 1'b0, v, oe);
                check("R7 true data after program", v, model[i]);
            end
            wait_rdy();
        end
        sweep("R3 first program sweep");
        for (int i = 0; i < 8; i++) begin
            prog4(i, pat(i, 3));
            model[i] &= pat(i, 3);
            wait_rdy();
        end
        sweep("R3 AND on reprogram");

        // R5 broken unlock sequences
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0012); wr(11'h2AA, 16'h0055);
        wr(11'h555, 16'h00A0); wr(11'd9, 16'h0000);
        @(negedge clk);
        check("R5 bad key2 no start", {15'b0, rdy}, 16'h1);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h444, 16'h00A0);
        wr(11'd9, 16'h0000);
        @(negedge clk);
        check("R5 bad command addr no start", {15'b0, rdy}, 16'h1);
        rd(11'd9, 1'b0, v, oe);
        check("R5 word unchanged", v, model[9]);

        // R2 reset in the middle of a program
        prog4(10, 16'h0000);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R2 ready after abort", {15'b0, rdy}, 16'h1);
        rd(11'd10, 1'b0, v, oe);
        check("R2 word keeps old value", v, model[10]);

        // R4 unlock bypass
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0020);
        for (int i = 16; i < 24; i++) begin
            wr(11'h123, 16'h00A0); wr(11'(i), pat(i, 7));
            model[i] &= pat(i, 7);
            wait_rdy();
        end
        sweep("R4 bypass program");
        wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
        wr(11'h000, 16'h00A0); wr(11'd20, 16'h0000);
        @(negedge clk);
        check("R4 exit then short program ignored", {15'b0, rdy}, 16'h1);
        rd(11'd20, 1'b0, v, oe);
        check("R4 word unchanged after exit", v, model[20]);

        // R9 sector erase of sector 2 via address 17
        erase_seq(11'd17, 8'h30);
        wait_rdy();
        for (int i = 16; i < 24; i++) model[i] = 16'hFFFF;
        sweep("R9 sector erase");

        // R11/R12 suspend and resume on sector 1
        erase_seq(11'd8, 8'h30);
        wr(11'h000, 16'h00B0);
        @(negedge clk);
        check("R11 ready while suspended", {15'b0, rdy}, 16'h1);
        rd(11'd3, 1'b0, v, oe);
        check("R11 other sector readable", v, model[3]);
        rd(11'd12, 1'b0, v, oe);
        check("R11 erased sector status bit7", {15'b0, v[7]}, 16'h1);
        prog4(27, 16'h0F0F);
        model[27] &= 16'h0F0F;
        check("R11 program outside accepted", {15'b0, rdy}, 16'h0);
        wait_rdy();
        rd(11'd27, 1'b0, v, oe);
        check("R11 program outside result", v, model[27]);
        prog4(9, 16'h0000);
        @(negedge clk);
        check("R11 program inside ignored", {15'b0, rdy}, 16'h1);
        wr(11'h000, 16'h0030);
        @(negedge clk);
        check("R12 resume busy", {15'b0, rdy}, 16'h0);
        wait_rdy();
        for (int i = 8; i < 16; i++) model[i] = 16'hFFFF;
        sweep("R12 erase completed");

        // R13 byte mode
        byte_n = 1'b0;
        rd(11'd27, 1'b0, v, oe);
        check("R13 low byte", v, {8'h00, model[27][7:0]});
        check("R13 drive low lanes", oe, 16'h00FF);
        rd(11'd27, 1'b1, v, oe);
        check("R13 high byte", v, {8'h00, model[27][15:8]});
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h8055); wr(11'h555, 16'h00A0);
        wr(11'd4, 16'h803C);
        model[4] &= 16'h3CFF;
        rd(11'd4, 1'b1, v, oe);
        check("R13 status lanes in byte mode", oe, 16'h00FF);
        wait_rdy();
        rd(11'd4, 1'b1, v, oe);
        check("R13 byte program high lane", v, {8'h00, model[4][15:8]});
        byte_n = 1'b1;
        rd(11'd4, 1'b0, v, oe);
        check("R13 full word after byte program", v, model[4]);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule